// File: doc/BRIEF.md
# Nanosecond-Timed PWM Output Bank

This block drives a bank of PWM outputs, one per channel (ten by default). Each channel is set up by a 64-bit configuration record. The record carries an enable flag, a polarity flag, a duty time and a period time, with both times given in nanoseconds. The block converts the two times into clock cycles for a fixed clock period and runs a free counter per channel, which produces the waveform.

Commands arrive on a valid/ready stream made of an 8-bit opcode and a 64-bit record.

- One opcode range loads a record into a channel.
- A second opcode range puts a channel into capture mode. That opcode carries no record, and the channel then holds its output at its idle level.

`cmd_ready` is held high at all times, so the sender never sees back-pressure. Each cycle with `cmd_valid` high delivers exactly one command. When the opcode is outside both ranges, the block flags it on a one-cycle error pulse.

To avoid runt pulses and glitches, a new setting waits in a pending slot. It replaces the running one only at the end of the current period. A channel that is not running picks up the pending setting on the next cycle.

Top module: `pwm_ns_bank`

## Requirements
- R1: `cmd_ready` is always high and a command is taken in every cycle where `cmd_valid` is high. Opcode 0x00+k (k = 0..9) loads `cmd_record` into channel k.
- R2: Record fields are as follows: bit 0 is enable (1 = running); bit 1 is polarity (1 = active high); bits [32:2] are the duty time in ns; bits [63:33] are the period time in ns.
- R3: A running channel repeats a cycle of P = period_ns/10 clocks, with the remainder dropped. Its output is active for the first D = duty_ns/10 clocks of each cycle, again with the remainder dropped.
- R4: With polarity 1, the active level is high and the idle level is low. With polarity 0, the active level is low and the idle level is high.
- R5: After reset every output is low. A channel whose record has enable 0 holds its idle level.
- R6: Opcode 0x60+k puts channel k into capture mode, which uses no record. From its next period boundary the channel holds its idle level. It stays there until the next load command for that channel.
- R7: If D >= P with P > 0, the output is constantly active. If P = 0, the output is constantly idle.
- R8: A command for a running channel takes effect only at the end of its current period, so no high or low run is shortened. For a non-running channel the command takes effect one cycle after acceptance.
- R9: Any other opcode leaves every channel unchanged. `cmd_err` is high for exactly the one cycle that follows acceptance of such an opcode, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (10 ns period assumed for scaling) |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted (always high) |
| cmd_opcode | input | 8 | Command opcode |
| cmd_record | input | 64 | Configuration record for load opcodes |
| pwm_out | output | NUM_CH | One PWM output per channel |
| cmd_err | output | 1 | One-cycle pulse for an unknown opcode |

## Verification
The checker watches the error pulse on every cycle, both its cause and its timing. It also checks, on every cycle, that a channel stays low until it receives a record that could make it drive high.

Some behaviours can only be shown by the bench's scenarios:
- duty and period scaling with truncation;
- polarity inversion;
- constant-active and constant-idle corner cases;
- capture hold;
- a mid-period reconfiguration that completes every run before switching.

// File: rtl/pwm_ns_pkg.sv
package pwm_ns_pkg;
  localparam int OP_W    = 8;
  localparam int REC_W   = 64;
  localparam int EN_BIT  = 0;
  localparam int POL_BIT = 1;
  localparam int DUTY_LO = 2;
  localparam int PER_LO  = 33;
  localparam int NS_W    = PER_LO - DUTY_LO;

  typedef struct packed {
    logic            cap;
    logic            en;
    logic            pol;
    logic [NS_W-1:0] duty;
    logic [NS_W-1:0] per;
  } chan_cfg_t;

  localparam chan_cfg_t CFG_RESET = '{cap: 1'b0, en: 1'b0, pol: 1'b1, duty: '0, per: '0};

  function automatic logic [NS_W-1:0] ns_to_cyc(input logic [NS_W-1:0] ns, input int unsigned clk_ns);
    return ns / NS_W'(clk_ns);
  endfunction

  function automatic chan_cfg_t unpack_rec(input logic [REC_W-1:0] rec, input int unsigned clk_ns);
    chan_cfg_t c;
    c.cap  = 1'b0;
    c.en   = rec[EN_BIT];
    c.pol  = rec[POL_BIT];
    c.duty = ns_to_cyc(rec[DUTY_LO +: NS_W], clk_ns);
    c.per  = ns_to_cyc(rec[PER_LO +: NS_W], clk_ns);
    return c;
  endfunction
endpackage

// File: rtl/pwm_cmd_decode.sv
module pwm_cmd_decode
  import pwm_ns_pkg::*;
#(
  parameter int NUM_CH    = 10,
  parameter int LOAD_BASE = 'h00,
  parameter int CAP_BASE  = 'h60
) (
  input  logic            fire,
  input  logic [OP_W-1:0] opcode,
  output logic [NUM_CH-1:0] load_oh,
  output logic [NUM_CH-1:0] cap_oh,
  output logic            bad
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    assign load_oh[i] = fire && (opcode == OP_W'(LOAD_BASE + i));
    assign cap_oh[i]  = fire && (opcode == OP_W'(CAP_BASE + i));
  end

  assign bad = fire && !(|load_oh) && !(|cap_oh);
endmodule

// File: rtl/pwm_ns_channel.sv
module pwm_ns_channel
  import pwm_ns_pkg::*;
#(
  parameter int CW = NS_W
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  chan_cfg_t load_cfg,
  input  logic      cap,
  output logic      pwm_o
);
  chan_cfg_t     act_q, pend_q;
  logic          pend_v_q;
  logic [CW-1:0] cnt_q;
  logic          run, wrap, bound, active;

  assign run   = act_q.en && !act_q.cap && (act_q.per != '0);
  assign wrap  = (cnt_q == (act_q.per - 1'b1));
  assign bound = !run || wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q    <= CFG_RESET;
      pend_q   <= CFG_RESET;
      pend_v_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      if (bound) begin
        cnt_q <= '0;
        if (pend_v_q) act_q <= pend_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (load) begin
        pend_q   <= load_cfg;
        pend_v_q <= 1'b1;
      end else if (cap) begin
        pend_q.cap <= 1'b1;
        pend_v_q   <= 1'b1;
      end else if (bound) begin
        pend_v_q <= 1'b0;
      end
    end
  end

  assign active = run && ((act_q.duty >= act_q.per) || (cnt_q < act_q.duty));
  assign pwm_o  = act_q.pol ? active : !active;
endmodule

// File: rtl/pwm_ns_bank.sv
module pwm_ns_bank
  import pwm_ns_pkg::*;
#(
  parameter int NUM_CH = 10,
  parameter int CLK_NS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [7:0]        cmd_opcode,
  input  logic [63:0]       cmd_record,
  output logic [NUM_CH-1:0] pwm_out,
  output logic              cmd_err
);
  logic              fire, bad;
  logic [NUM_CH-1:0] load_oh, cap_oh;
  chan_cfg_t         new_cfg;

  assign cmd_ready = 1'b1;
  assign fire      = cmd_valid && cmd_ready;
  assign new_cfg   = unpack_rec(cmd_record, CLK_NS);

  pwm_cmd_decode #(.NUM_CH(NUM_CH)) dec_i (
    .fire(fire), .opcode(cmd_opcode), .load_oh(load_oh), .cap_oh(cap_oh), .bad(bad)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    pwm_ns_channel ch_i (
      .clk(clk), .rst_n(rst_n), .load(load_oh[k]), .load_cfg(new_cfg),
      .cap(cap_oh[k]), .pwm_o(pwm_out[k])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cmd_err <= 1'b0;
    else        cmd_err <= bad;
  end
endmodule

module pwm_ns_bank_chk #(
  parameter int NUM_CH = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [7:0]        cmd_opcode,
  input logic [1:0]        rec_flags,
  input logic [NUM_CH-1:0] pwm_out,
  input logic              cmd_err
);
  logic              fire, unknown;
  logic [NUM_CH-1:0] armed_q;

  assign fire    = cmd_valid && cmd_ready;
  assign unknown = !(cmd_opcode < 8'(NUM_CH)) &&
                   !((cmd_opcode >= 8'h60) && (cmd_opcode < 8'(8'h60 + NUM_CH)));

  for (genvar k = 0; k < NUM_CH; k++) begin : g_arm
    always_ff @(posedge clk) begin
      if (!rst_n) armed_q[k] <= 1'b0;
      else if (fire && (cmd_opcode == 8'(k)) && (rec_flags[0] || !rec_flags[1]))
        armed_q[k] <= 1'b1;
    end
    // R5
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_q[k] |-> !pwm_out[k]);
  end

  // R9
  err_on_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && unknown) |=> cmd_err);
  // R9
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(fire && unknown));
  // R1
  ready_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_ready);
endmodule

bind pwm_ns_bank pwm_ns_bank_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_opcode(cmd_opcode), .rec_flags(cmd_record[1:0]), .pwm_out(pwm_out),
  .cmd_err(cmd_err)
);

// File: tb/pwm_ns_bank_tb.sv
module pwm_ns_bank_tb_top;
  localparam int NCH = 10;
  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cmd_valid = 1'b0;
  logic           cmd_ready;
  logic [7:0]     cmd_opcode = '0;
  logic [63:0]    cmd_record = '0;
  logic [NCH-1:0] pwm_out;
  logic           cmd_err;
  int             n_chk = 0;
  int             n_fail = 0;

  always #10 clk = ~clk;

  pwm_ns_bank #(.NUM_CH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_opcode(cmd_opcode), .cmd_record(cmd_record), .pwm_out(pwm_out), .cmd_err(cmd_err)
  );

  function automatic logic [63:0] mk(input bit en, input bit pol, input int unsigned d, input int unsigned p);
    return {p[30:0], d[30:0], pol, en};
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] op, input logic [63:0] rec, output logic err);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_opcode = op; cmd_record = rec;
    @(negedge clk);
    cmd_valid = 1'b0;
    err = cmd_err;
  endtask

  task automatic measure(input int ch, input int n, output int hi, output int rises);
    logic prev;
    hi = 0; rises = 0;
    @(negedge clk);
    prev = pwm_out[ch];
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out[ch]) hi++;
      if (pwm_out[ch] && !prev) rises++;
      prev = pwm_out[ch];
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R5", "outputs after reset", int'(pwm_out), 0);
    check("R9", "err after reset", int'(cmd_err), 0);
    check("R1", "ready after reset", int'(cmd_ready), 1);
  endtask

  task automatic t_basic();
    logic e; int h, r;
    send(8'h00, mk(1, 1, 30, 100), e);
    check("R9", "err on valid load", int'(e), 0);
    wait_cyc(3);
    measure(0, 100, h, r);
    check("R1", "ch0 high cycles", h, 30);
    check("R3", "ch0 periods", r, 10);
  endtask

  task automatic t_trunc();
    logic e; int h, r;
    send(8'h01, mk(1, 1, 39, 105), e);
    wait_cyc(3);
    measure(1, 100, h, r);
    check("R3", "ch1 truncated duty", h, 30);
    check("R2", "ch1 truncated period", r, 10);
  endtask

  task automatic t_pol();
    logic e; int h, r;
    send(8'h02, mk(1, 0, 20, 80), e);
    wait_cyc(3);
    measure(2, 80, h, r);
    check("R4", "ch2 active-low high cycles", h, 60);
  endtask

  task automatic t_disabled();
    logic e; int h, r;
    send(8'h03, mk(0, 1, 30, 100), e);
    wait_cyc(3);
    measure(3, 20, h, r);
    check("R5", "disabled pol1 idle low", h, 0);
    send(8'h03, mk(0, 0, 30, 100), e);
    wait_cyc(3);
    measure(3, 20, h, r);
    check("R5", "disabled pol0 idle high", h, 20);
  endtask

  task automatic t_corners();
    logic e; int h, r;
    send(8'h04, mk(1, 1, 100, 100), e);
    wait_cyc(3);
    measure(4, 40, h, r);
    check("R7", "duty equal period", h, 40);
    send(8'h04, mk(1, 1, 150, 100), e);
    wait_cyc(12);
    measure(4, 40, h, r);
    check("R7", "duty above period", h, 40);
    send(8'h05, mk(1, 1, 50, 0), e);
    wait_cyc(3);
    measure(5, 30, h, r);
    check("R7", "zero period", h, 0);
    send(8'h05, mk(1, 1, 5, 9), e);
    wait_cyc(3);
    measure(5, 30, h, r);
    check("R7", "period truncated to zero", h, 0);
  endtask

  task automatic t_capture();
    logic e; int h, r;
    send(8'h60, 64'h0, e);
    check("R6", "err on capture", int'(e), 0);
    wait_cyc(15);
    measure(0, 50, h, r);
    check("R6", "ch0 idle in capture", h, 0);
    send(8'h00, mk(1, 1, 30, 100), e);
    wait_cyc(3);
    measure(0, 100, h, r);
    check("R6", "ch0 resumes after reload", h, 30);
  endtask

  task automatic t_bad();
    logic e; int h, r;
    logic [7:0] ops [4] = '{8'h0A, 8'h5F, 8'h6A, 8'hFF};
    foreach (ops[i]) begin
      send(ops[i], mk(1, 0, 0, 0), e);
      check("R9", $sformatf("err for 0x%02h", ops[i]), int'(e), 1);
      @(negedge clk);
      check("R9", "err one cycle only", int'(cmd_err), 0);
    end
    measure(1, 100, h, r);
    check("R9", "ch1 unchanged by bad opcodes", h, 30);
    measure(3, 10, h, r);
    check("R9", "ch3 unchanged by bad opcodes", h, 10);
  endtask

  task automatic t_boundary();
    logic e; logic prev; int run_len, saw_new, bad_runs, started;
    send(8'h06, mk(1, 1, 50, 100), e);
    wait_cyc(3);
    prev = pwm_out[6]; run_len = 0; saw_new = 0; bad_runs = 0; started = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (i == 13) begin
        cmd_valid = 1'b1; cmd_opcode = 8'h06; cmd_record = mk(1, 1, 20, 40);
      end else if (i == 14) begin
        cmd_valid = 1'b0;
      end
      if (pwm_out[6] != prev) begin
        if (started != 0) begin
          if (run_len == 2) saw_new++;
          else if (run_len != 5) bad_runs++;
        end
        started = 1;
        run_len = 1;
      end else begin
        run_len++;
      end
      prev = pwm_out[6];
    end
    check("R8", "runs of wrong length", bad_runs, 0);
    check("R8", "new setting applied", int'(saw_new > 0), 1);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset();
    t_basic();
    t_trunc();
    t_pol();
    t_disabled();
    t_corners();
    t_capture();
    t_bad();
    t_boundary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule